// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Receive Queue

This block recovers bytes from an asynchronous serial line in the usual one-start, eight-data, one-stop format. It uses an oversampling tick that pulses sixteen times per bit period. The line first passes through a multi-stage synchronizer. The receiver then waits for a falling edge. Half a bit later it confirms the start bit. After that it takes each following bit at the middle of its window, least significant bit first, up to and including the stop bit.

Each received byte is queued together with four error tags: overrun, break, parity and framing. The queue has sixteen entries. Its head is presented to the host on a valid/ready stream. The host takes an entry by holding `rd_ready` high in a cycle where `rd_valid` is high. While `rd_ready` stays low, the head entry stays on `rd_data` unchanged. The serial side cannot be stalled, so a frame that completes while the queue is full is dropped and reported as an overrun.

A sticky four-bit status word collects the same error events. A single-cycle pulse on `err_clr` clears it, whatever value the host writes. Parity is not generated or checked, so the parity tag always reads 0. The oversampling tick is supplied from outside the block.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, `rx_empty` is 1, `rx_full` is 0, `rd_valid` is 0 and `err_status` is 0.
- R2: A frame is a low start bit, then eight data bits least significant bit first, then a stop bit. It is stored as a 12-bit entry: bits [7:0] hold the data, bit 8 the framing error, bit 9 the parity error, bit 10 the break and bit 11 the overrun.
- R3: The start bit is sampled on the eighth oversampling tick after the falling edge. If the line reads 1 at that point, the receiver discards the event, stores no entry and waits for a new edge.
- R4: A stop bit sampled as 0 sets the framing error tag (bit 8) of that entry.
- R5: A frame in which the start bit, all data bits and the stop bit are all low is stored as a break: data 0, with bits 10 and 8 set. The receiver then starts no new frame until the line has returned high.
- R6: The parity error tag (entry bit 9, status bit 1) is always 0.
- R7: The queue holds 16 entries and returns them in arrival order. `rx_full` is 1 while 16 entries are held. `rx_empty` is 1 when no entry is held, and it rises only through a pop.
- R8: `rd_valid` equals the inverse of `rx_empty`. An entry is removed in a cycle where `rd_valid` and `rd_ready` are both 1. While `rd_ready` is 0, `rd_data` holds steady.
- R9: A frame that completes while 16 entries are held is lost. Its loss sets status bit 3, and the next entry stored afterwards carries the overrun tag (bit 11).
- R10: `err_status` bits are [3] overrun, [2] break, [1] parity, [0] framing. Each bit is set by its event, holds until `err_clr`, and is then cleared. An event in the same cycle as `err_clr` is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit period |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| rd_valid | output | 1 | Head entry available |
| rd_ready | input | 1 | Host accepts the head entry |
| rd_data | output | 12 | Head entry: tags [11:8], data [7:0] |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue holds 16 entries |
| err_status | output | 4 | Sticky error flags |
| err_clr | input | 1 | Write strobe that clears the error flags |

## Verification
The bench builds the block with its defaults: a queue depth of 16, sixteen ticks per bit and two synchronizer stages. The tick pulses every fourth clock, so one frame lasts about 700 cycles. That is short enough to fill all sixteen entries and then push a seventeenth frame, which exercises the full flag, the lost frame and the overrun tag on the following entry. The same settings also reach a short low pulse that is rejected as a glitch, a line held low long enough to count as a break, and a bad stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DATA_W  = 8;
  localparam int RX_TAG_W   = 4;
  localparam int RX_ENTRY_W = RX_DATA_W + RX_TAG_W;

  // status word bit positions
  localparam int ST_FE = 0;
  localparam int ST_PE = 1;
  localparam int ST_BE = 2;
  localparam int ST_OE = 3;

  typedef struct packed {
    logic                 oe;
    logic                 be;
    logic                 pe;
    logic                 fe;
    logic [RX_DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BRKWAIT
  } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);

  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b1;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign dout = stage_q[STAGES-1];
  assign fall = prev_q & ~stage_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 fall,
  output logic                 done,
  output logic [RX_DATA_W-1:0] data,
  output logic                 fe,
  output logic                 be
);

  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(RX_DATA_W);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(RX_DATA_W - 1);

  rx_state_t            st_q;
  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q;
  logic [RX_DATA_W-1:0] shr_q;
  logic                 all_low;

  assign all_low = (shr_q == '0) && !rxd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      shr_q <= '0;
      done  <= 1'b0;
      data  <= '0;
      fe    <= 1'b0;
      be    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (fall) begin
            cnt_q <= '0;
            st_q  <= RX_START;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt_q == HALF_LAST) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rxd ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt_q == FULL_LAST) begin
              cnt_q <= '0;
              shr_q <= {rxd, shr_q[RX_DATA_W-1:1]};
              if (idx_q == IDX_LAST) st_q <= RX_STOP;
              else                   idx_q <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt_q == FULL_LAST) begin
              cnt_q <= '0;
              done  <= 1'b1;
              data  <= shr_q;
              fe    <= !rxd;
              be    <= all_low;
              st_q  <= all_low ? RX_BRKWAIT : RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_BRKWAIT: begin
          if (rxd) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q;
  logic [AW-1:0]    rptr_q;
  logic [AW:0]      cnt_q;
  logic             do_push;
  logic             do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rptr_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick16,
  input  logic                  rx_serial,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [RX_ENTRY_W-1:0] rd_data,
  output logic                  rx_empty,
  output logic                  rx_full,
  output logic [RX_TAG_W-1:0]   err_status,
  input  logic                  err_clr
);

  logic                 rxd;
  logic                 rx_fall;
  logic                 frm_done;
  logic [RX_DATA_W-1:0] frm_data;
  logic                 frm_fe;
  logic                 frm_be;
  logic                 lost;
  logic                 push;
  logic                 oe_pend_q;
  rx_entry_t            entry;
  logic [RX_TAG_W-1:0]  ev_bits;
  logic [RX_TAG_W-1:0]  status_d;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (rxd),
    .fall (rx_fall)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick16),
    .rxd  (rxd),
    .fall (rx_fall),
    .done (frm_done),
    .data (frm_data),
    .fe   (frm_fe),
    .be   (frm_be)
  );

  assign lost = frm_done && rx_full;
  assign push = frm_done && !rx_full;

  always_comb begin
    entry.oe   = oe_pend_q;
    entry.be   = frm_be;
    entry.pe   = 1'b0;
    entry.fe   = frm_fe;
    entry.data = frm_data;
  end

  uart_rx_fifo #(.WIDTH(RX_ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(entry),
    .pop      (rd_ready),
    .head     (rd_data),
    .empty    (rx_empty),
    .full     (rx_full)
  );

  assign rd_valid = !rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)     oe_pend_q <= 1'b0;
    else if (lost)  oe_pend_q <= 1'b1;
    else if (push)  oe_pend_q <= 1'b0;
  end

  always_comb begin
    ev_bits        = '0;
    ev_bits[ST_OE] = lost;
    ev_bits[ST_BE] = frm_done && frm_be;
    ev_bits[ST_PE] = 1'b0;
    ev_bits[ST_FE] = frm_done && frm_fe;
    status_d       = (err_clr ? '0 : err_status) | ev_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_status <= '0;
    else        err_status <= status_d;
  end

endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [11:0] rd_data,
  input logic        rx_empty,
  input logic        rx_full,
  input logic [3:0]  err_status,
  input logic        err_clr,
  input logic        frame_done
);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_full_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> (rd_valid && !rx_empty));

  p_empty_by_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_empty) |-> $past(rd_ready));

  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full) |=> err_status[3]);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !frame_done) |=> (err_status == 4'b0000));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_status & $past(err_status)) == $past(err_status)));

  p_parity_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_status[1]) && (!rd_valid || !rd_data[9]));

endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .rx_empty  (rx_empty),
  .rx_full   (rx_full),
  .err_status(err_status),
  .err_clr   (err_clr),
  .frame_done(frm_done)
);

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;

  localparam int BIT_CLKS = 64;   // 16 ticks x 4 clocks
  localparam int NVEC = 6;
  // {stop bit, data byte, expected entry}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 8'h55, 12'h055},
    {1'b1, 8'hA3, 12'h0A3},
    {1'b1, 8'h00, 12'h000},
    {1'b1, 8'hFF, 12'h0FF},
    {1'b0, 8'h3C, 12'h13C},
    {1'b1, 8'h81, 12'h081}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b0;
  logic        rx_serial = 1'b1;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [11:0] rd_data;
  logic        rx_empty;
  logic        rx_full;
  logic [3:0]  err_status;
  logic        err_clr = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] tdiv = '0;
  logic done_flag = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_rx_tagged dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rx_empty(rx_empty), .rx_full(rx_full),
    .err_status(err_status), .err_clr(err_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    rx_serial = 1'b0;
    wait_clks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rx_serial = d[i];
      wait_clks(BIT_CLKS);
    end
    rx_serial = stop;
    wait_clks(BIT_CLKS);
    rx_serial = 1'b1;
    wait_clks(BIT_CLKS);
  endtask

  task automatic pop_check(input string tag, input logic [11:0] exp);
    int guard = 0;
    @(negedge clk);
    while (!rd_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(tag, {20'd0, rd_data}, {20'd0, exp});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_clks(5);
    // R1 reset state
    chk("R1 empty", {31'd0, rx_empty}, 32'd1);
    chk("R1 full", {31'd0, rx_full}, 32'd0);
    chk("R1 valid", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    wait_clks(3);
    chk("R1 status", {28'd0, err_status}, 32'd0);

    // R2 / R4 / R6 vector table
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][19:12], VEC[v][20]);
      pop_check($sformatf("R2 R4 R6 vector %0d", v), VEC[v][11:0]);
    end
    chk("R4 status FE", {28'd0, err_status}, 32'h1);
    chk("R6 status PE", {31'd0, err_status[1]}, 32'd0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    wait_clks(2);
    chk("R10 clear", {28'd0, err_status}, 32'd0);

    // R3 glitch: low for 3 ticks only
    rx_serial = 1'b0;
    wait_clks(12);
    rx_serial = 1'b1;
    wait_clks(12 * BIT_CLKS);
    chk("R3 glitch no entry", {31'd0, rx_empty}, 32'd1);

    // R8 stall hold
    send_frame(8'hC6, 1'b1);
    chk("R8 valid", {31'd0, rd_valid}, 32'd1);
    chk("R8 data", {20'd0, rd_data}, 32'h0C6);
    wait_clks(20);
    chk("R8 held", {20'd0, rd_data}, 32'h0C6);
    pop_check("R8 pop", 12'h0C6);
    wait_clks(2);
    chk("R8 empty after pop", {31'd0, rx_empty}, 32'd1);

    // R5 break: line low for 20 bit times
    rx_serial = 1'b0;
    wait_clks(20 * BIT_CLKS);
    pop_check("R5 break entry", 12'h500);
    wait_clks(2);
    chk("R5 no frame while low", {31'd0, rx_empty}, 32'd1);
    rx_serial = 1'b1;
    wait_clks(2 * BIT_CLKS);
    chk("R10 status BE FE", {28'd0, err_status}, 32'h5);
    send_frame(8'h5A, 1'b1);
    pop_check("R5 frame after break", 12'h05A);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    wait_clks(2);
    chk("R10 clear after break", {28'd0, err_status}, 32'd0);

    // R7 / R9 fill and overrun
    for (int i = 0; i < 16; i++) send_frame(8'h10 + 8'(i), 1'b1);
    chk("R7 full", {31'd0, rx_full}, 32'd1);
    chk("R9 no overrun yet", {28'd0, err_status}, 32'd0);
    send_frame(8'hEE, 1'b1);
    chk("R9 overrun status", {28'd0, err_status}, 32'h8);
    chk("R7 still full", {31'd0, rx_full}, 32'd1);
    for (int i = 0; i < 16; i++)
      pop_check($sformatf("R7 order %0d", i), {4'h0, 8'h10 + 8'(i)});
    wait_clks(2);
    chk("R7 empty after drain", {31'd0, rx_empty}, 32'd1);
    send_frame(8'h77, 1'b1);
    pop_check("R9 overrun tag", 12'h877);
    send_frame(8'h78, 1'b1);
    pop_check("R9 tag once", 12'h078);

    finish_run();
  end

endmodule